// File: doc/BRIEF.md
# Gated Overcurrent Qualifier

This block turns a raw overcurrent comparator bit into a clean fault event for a switching regulator controller. The comparator reports whether the voltage across the high-side switch exceeds a programmed limit. That bit is only meaningful while the high-side gate is on, and it is noisy just after the switch turns on. The block looks at the comparator only while the high-side gate is on and detection is armed. It ignores a fixed settling window after each turn-on. It also requires the comparator to stay high without a break for a qualification window that runs in parallel with the settling window.

The controller raises `arm` when it enables the gate drivers, and lowers it while the drivers are held off. Each qualified fault appears on `oc_event` as a pulse one clock long. The window lengths are parameters in clock ticks, and the defaults give 120 ns at a 100 MHz clock. Both windows start together on the first clock edge that sees the gate on while armed. A falling gate clears all progress.

Top module: `ocp_blank_qual`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `oc_event` is 0.
- R2: When `top_on` is 0, `cmp_raw` is ignored and `oc_event` stays 0.
- R3: When `arm` is 0, `cmp_raw` and `top_on` are ignored and `oc_event` stays 0.
- R4: A "live" sample is a rising clock edge at which `arm` and `top_on` are both 1. Suppose `cmp_raw` is 1 from the first live sample of an interval onward. Then `oc_event` goes to 1 just after the BLANK_TICKS-th consecutive live sample, and not earlier.
- R5: An event also needs FILT_TICKS consecutive live samples with `cmp_raw` = 1. A single sample with `cmp_raw` = 0 restarts that count. The count runs during the blanking window as well as after it.
- R6: `oc_event` is high for exactly one cycle. There is at most one event per unbroken run of live samples, even if `cmp_raw` stays at 1.
- R7: A sample that is not live clears both counts. A gate-on run shorter than BLANK_TICKS samples never produces an event, and the next run starts from zero.
- R8: If `arm` rises while `top_on` is already 1, the windows start from the first live sample, just as they would at a turn-on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| arm | input | 1 | Detection enable, high while the gate drivers are enabled |
| top_on | input | 1 | High-side gate on |
| cmp_raw | input | 1 | Raw overcurrent comparator bit |
| oc_event | output | 1 | Qualified overcurrent pulse, one cycle long |

## Verification
The assertions assume that `arm`, `top_on` and `cmp_raw` are synchronous to `clk`, so each one has a single defined value at every edge. They also assume that both window parameters are at least 1. The bench changes every input only on the falling edge. Its random phase draws gate-on runs from 1 to 30 ticks, which covers intervals both shorter and longer than the blank. It toggles `cmp_raw` often enough that the qualification count is broken at many different points.

// File: rtl/ocp_blank_qual.sv
module ocp_blank_qual #(
  parameter int BLANK_TICKS = 12,
  parameter int FILT_TICKS  = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic top_on,
  input  logic cmp_raw,
  output logic oc_event
);

  localparam int BW = $clog2(BLANK_TICKS + 1);
  localparam int FW = $clog2(FILT_TICKS + 1);
  localparam logic [BW-1:0] BLANK_MAX = BW'(BLANK_TICKS);
  localparam logic [FW-1:0] FILT_MAX  = FW'(FILT_TICKS);

  logic          live;
  logic [BW-1:0] age_q, age_d;
  logic [FW-1:0] run_q, run_d;
  logic          fired_q;
  logic          hit;

  assign live = arm & top_on;

  always_comb begin
    if (!live)                   age_d = '0;
    else if (age_q == BLANK_MAX) age_d = age_q;
    else                         age_d = age_q + BW'(1);

    if (!(live && cmp_raw))      run_d = '0;
    else if (run_q == FILT_MAX)  run_d = run_q;
    else                         run_d = run_q + FW'(1);
  end

  assign hit = live && (age_d == BLANK_MAX) && (run_d == FILT_MAX) && !fired_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age_q    <= '0;
      run_q    <= '0;
      fired_q  <= 1'b0;
      oc_event <= 1'b0;
    end else begin
      age_q    <= age_d;
      run_q    <= run_d;
      fired_q  <= live & (fired_q | hit);
      oc_event <= hit;
    end
  end

endmodule

// File: rtl/ocp_blank_qual_chk.sv
module ocp_blank_qual_chk #(
  parameter int BLANK_TICKS = 12,
  parameter int FILT_TICKS  = 12
) (
  input logic clk,
  input logic rst_n,
  input logic arm,
  input logic top_on,
  input logic cmp_raw,
  input logic oc_event
);

  int  live_cnt;
  int  high_cnt;
  logic seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_cnt <= 0;
      high_cnt <= 0;
      seen     <= 1'b0;
    end else begin
      live_cnt <= (arm && top_on) ? ((live_cnt < BLANK_TICKS) ? live_cnt + 1 : live_cnt) : 0;
      high_cnt <= (arm && top_on && cmp_raw) ? ((high_cnt < FILT_TICKS) ? high_cnt + 1 : high_cnt) : 0;
      seen     <= (arm && top_on) ? (seen | oc_event) : 1'b0;
    end
  end

  a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    oc_event |=> !oc_event);

  a_r2_needs_top: assert property (@(posedge clk) disable iff (!rst_n)
    oc_event |-> $past(top_on));

  a_r3_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    oc_event |-> $past(arm));

  a_r5_cmp_high: assert property (@(posedge clk) disable iff (!rst_n)
    oc_event |-> $past(cmp_raw));

  a_r4_blank_done: assert property (@(posedge clk) disable iff (!rst_n)
    oc_event |-> live_cnt >= BLANK_TICKS);

  a_r5_filter_done: assert property (@(posedge clk) disable iff (!rst_n)
    oc_event |-> high_cnt >= FILT_TICKS);

  a_r6_once_per_run: assert property (@(posedge clk) disable iff (!rst_n)
    oc_event |-> !seen);

endmodule

bind ocp_blank_qual ocp_blank_qual_chk #(
  .BLANK_TICKS(BLANK_TICKS),
  .FILT_TICKS (FILT_TICKS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .arm     (arm),
  .top_on  (top_on),
  .cmp_raw (cmp_raw),
  .oc_event(oc_event)
);

// File: tb/ocp_blank_qual_test.sv
module ocp_blank_qual_test;
  localparam int B = 12;
  localparam int F = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0, top_on = 1'b0, cmp_raw = 1'b0;
  logic oc_event;

  int checks = 0, errors = 0, events = 0;
  int m_age = 0, m_run = 0;
  bit m_fired = 0, exp_ev = 0, done = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  ocp_blank_qual #(.BLANK_TICKS(B), .FILT_TICKS(F)) uut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .top_on(top_on),
    .cmp_raw(cmp_raw), .oc_event(oc_event));

  function automatic int sat(input int v, input int lim);
    return (v > lim) ? lim : v;
  endfunction

  task automatic check(input string t, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: oc_event=%0b expected %0b", t, act, expv);
    end
  endtask

  task automatic step(input logic a, input logic t, input logic c);
    bit hit;
    @(negedge clk);
    check(tag, oc_event, exp_ev);
    if (oc_event === 1'b1) events++;
    arm = a; top_on = t; cmp_raw = c;
    hit = 0;
    if (a && t) begin
      m_age = sat(m_age + 1, B);
      m_run = c ? sat(m_run + 1, F) : 0;
      hit = (m_age >= B) && (m_run >= F) && !m_fired;
      m_fired = m_fired | hit;
    end else begin
      m_age = 0; m_run = 0; m_fired = 0;
    end
    exp_ev = hit;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c9a));
    repeat (3) @(negedge clk);
    check("R1 in reset", oc_event, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", oc_event, 1'b0);

    tag = "R2 gate off";
    repeat (30) step(1, 0, 1);

    tag = "R3 disarmed";
    repeat (30) step(0, 1, 1);
    step(0, 0, 0);

    tag = "R4 blank from turn-on";
    events = 0;
    repeat (B - 1) step(1, 1, 1);
    step(1, 1, 1);
    step(1, 1, 1);
    check("R4 event one cycle after blank", oc_event, 1'b1);
    repeat (20) step(1, 1, 1);
    step(1, 0, 0);
    check("R6 one event per interval", logic'(events == 1), 1'b1);

    tag = "R5 restart on low sample";
    repeat (5) step(1, 1, 1);
    step(1, 1, 0);
    repeat (F - 1) step(1, 1, 1);
    step(1, 1, 1);
    check("R5 no event before full filter", oc_event, 1'b0);
    step(1, 1, 1);
    check("R5 event after full filter", oc_event, 1'b1);
    repeat (4) step(1, 1, 1);
    step(1, 0, 0);

    tag = "R7 short pulses";
    events = 0;
    for (int k = 0; k < 6; k++) begin
      repeat (B - 1) step(1, 1, 1);
      repeat (2) step(1, 0, 1);
    end
    check("R7 no event on short pulses", logic'(events == 0), 1'b1);

    tag = "R8 arm while gate on";
    repeat (6) step(0, 1, 1);
    repeat (B + 4) step(1, 1, 1);
    step(1, 0, 0);

    tag = "R5 random mix";
    for (int k = 0; k < 300; k++) begin
      int len = 1 + ($urandom % 30);
      logic a = ($urandom % 8) != 0;
      for (int j = 0; j < len; j++)
        step(a, 1, ($urandom % 16) != 0);
      repeat (1 + ($urandom % 4)) step(a, 0, logic'($urandom % 2));
    end
    step(1, 0, 0);
    step(1, 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule